// File: doc/BRIEF.md
# Boot-Overlay Bus Address Decoder

This block sits between a 24-bit big-endian processor bus and three on-chip byte stores. The bus issues byte, word or longword transfers, and the block sends each one to a region: a read-only boot image, main RAM, a video RAM window, or the control-register space. The block builds the read data from per-byte lanes and derives a write enable for each lane from the access size and the low address bits.

Out of reset a boot overlay is in force. Address bit 23 is set on every access before decoding, so the boot image answers at address zero and the reset vectors can be fetched. Software switches to the normal map by setting a flag through one control register. Once the flag is set, low addresses reach main RAM.

Store sizes are parameters. The boot image is filled at elaboration from a computed byte pattern. Reads take one cycle.

Top module: `boot_overlay_bus_decoder`

## Requirements
- R1: Synchronous reset clears `map_normal`. While `map_normal` is 0, bit 23 of the request address is set before decoding, so address 0x000000+k reads boot-image byte k and never selects RAM or video RAM.
- R2: Effective addresses 0x800000..0xBFFFFF select the boot image, at offset `addr & (ROM_BYTES-1)`, so the image repeats across the window. The byte at offset k is `k[7:0] ^ k[15:8] ^ 8'hC3`.
- R3: When R2 does not apply, effective addresses below `RAM_BYTES` select main RAM. Main RAM returns what was last written to each byte.
- R4: When neither R2 nor R3 applies, effective addresses 0x420000..0x427FFF select video RAM, indexed by `addr & (VRAM_BYTES-1)`, so the store repeats inside the 32 KiB window.
- R5: `req_size` 0 is a byte access, 1 is a word access, and 2 or 3 is a longword access. Data is big-endian and right-justified: the lowest-addressed byte sits in the most significant used lane, and unused upper bits of `rd_data` read 0.
- R6: A write that lands in the boot-image region changes no stored byte.
- R7: A write to effective address 0xE43000 loads `map_normal`. Word and longword writes take it from `req_wdata[15]`. Byte writes take it from `req_wdata[7]`.
- R8: A read in the register space, 0xE43000 included, returns all ones at the width of the access (0xFF, 0xFFFF or 0xFFFFFFFF).
- R9: `region_sel` is one-hot: bit0 is the boot image, bit1 main RAM, bit2 video RAM, bit3 the register space. Priority runs in that order. It shows the region of the request from the previous cycle, and is 0 when there was no request.
- R10: A register-space write to any address other than 0xE43000 leaves `map_normal` unchanged. Any register-space access, other than a write to 0xE43000, raises `unmapped_pulse` for one cycle, the cycle after the request.
- R11: A read request is answered one cycle later with `rd_valid` high for one cycle. Writes never raise `rd_valid`.
- R12: A write changes only the bytes it addresses. A byte written into a stored longword leaves the other three bytes as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 word, 2/3 longword |
| req_addr | input | 24 | Byte address of the lowest byte |
| req_wdata | input | 32 | Right-justified write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Right-justified read data |
| region_sel | output | 4 | One-hot region of the last request |
| unmapped_pulse | output | 1 | Unserviced register-space access |
| map_normal | output | 1 | 0 = boot overlay active |

## Verification
The bench targets the points where the overlay and the decoder interact. It writes RAM in the normal map, restores the overlay, and writes the same low address again. A decoder that skipped the forcing step would corrupt RAM or return RAM data instead of the image byte. The control register is loaded with values whose bit 7 and bit 15 differ. This catches a design that reads the wrong data bit for the access size, or that updates the flag from a neighbouring register address. Longwords that start on a two-byte boundary, and mirrored window addresses for the image and video RAM, expose lane-rotation and masking errors as swapped or wrong bytes.

// File: rtl/bdec_pkg.sv
package bdec_pkg;

  localparam int unsigned ADDR_W = 24;

  localparam logic [ADDR_W-1:0] BOOT_LO   = 24'h800000;
  localparam logic [ADDR_W-1:0] BOOT_HI   = 24'hBFFFFF;
  localparam logic [ADDR_W-1:0] VID_LO    = 24'h420000;
  localparam logic [ADDR_W-1:0] VID_HI    = 24'h427FFF;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 24'hE43000;
  localparam logic [ADDR_W-1:0] OVERLAY_OR = 24'h800000;

  typedef enum logic [1:0] {
    RG_BOOT = 2'd0,
    RG_RAM  = 2'd1,
    RG_VID  = 2'd2,
    RG_REG  = 2'd3
  } region_e;

  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [31:0] ones_of(input logic [2:0] nb);
    case (nb)
      3'd1:    return 32'h0000_00FF;
      3'd2:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [7:0] boot_pattern(input logic [31:0] k);
    return k[7:0] ^ k[15:8] ^ 8'hC3;
  endfunction

endpackage

// File: rtl/bdec_region_decode.sv
module bdec_region_decode
  import bdec_pkg::*;
#(
  parameter int unsigned RAM_BYTES = 4096
) (
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              map_normal,
  output logic [ADDR_W-1:0] eff_addr,
  output region_e           region,
  output logic              is_ctrl
);

  localparam logic [ADDR_W:0] RAM_LIM = (ADDR_W+1)'(RAM_BYTES);

  always_comb begin
    eff_addr = map_normal ? req_addr : (req_addr | OVERLAY_OR);
    is_ctrl  = 1'b0;
    if (eff_addr >= BOOT_LO && eff_addr <= BOOT_HI) begin
      region = RG_BOOT;
    end else if ({1'b0, eff_addr} < RAM_LIM) begin
      region = RG_RAM;
    end else if (eff_addr >= VID_LO && eff_addr <= VID_HI) begin
      region = RG_VID;
    end else begin
      region  = RG_REG;
      is_ctrl = (eff_addr == CTRL_ADDR);
    end
  end

endmodule

// File: rtl/bdec_lane_steer.sv
module bdec_lane_steer #(
  parameter int unsigned MEM_BYTES = 4096,
  localparam int unsigned AW = $clog2(MEM_BYTES),
  localparam int unsigned RW = AW - 2
) (
  input  logic [AW-1:0]         base,
  input  logic [2:0]            nbytes,
  input  logic                  wr,
  input  logic [31:0]           wdata,
  output logic [3:0][RW-1:0]    row,
  output logic [3:0]            we,
  output logic [3:0][7:0]       wbyte
);

  for (genvar L = 0; L < 4; L++) begin : g_lane
    logic [1:0]    pos;
    logic [AW-1:0] baddr;
    logic [2:0]    sh;

    assign pos      = 2'(L) - base[1:0];
    assign baddr    = base + AW'(pos);
    assign row[L]   = baddr[AW-1:2];
    assign we[L]    = wr && ({1'b0, pos} < nbytes);
    assign sh       = nbytes - 3'd1 - {1'b0, pos};
    assign wbyte[L] = 8'(wdata >> {sh, 3'b000});
  end

endmodule

// File: rtl/bdec_ram_lane.sv
module bdec_ram_lane #(
  parameter int unsigned ROWS = 1024,
  localparam int unsigned RW = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [RW-1:0] row,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);

  logic [7:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (we) mem[row] <= wdata;
    rdata <= mem[row];
  end

endmodule

// File: rtl/bdec_rom_lane.sv
module bdec_rom_lane
  import bdec_pkg::*;
#(
  parameter int unsigned ROWS = 256,
  parameter int unsigned LANE = 0,
  localparam int unsigned RW = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic [RW-1:0] row,
  output logic [7:0]    rdata
);

  logic [7:0] mem [ROWS];

  initial begin
    for (int r = 0; r < int'(ROWS); r++) begin
      mem[r] = boot_pattern(32'(r * 4 + int'(LANE)));
    end
  end

  always_ff @(posedge clk) begin
    rdata <= mem[row];
  end

endmodule

// File: rtl/boot_overlay_bus_decoder.sv
module boot_overlay_bus_decoder
  import bdec_pkg::*;
#(
  parameter int unsigned ROM_BYTES  = 1024,
  parameter int unsigned RAM_BYTES  = 4096,
  parameter int unsigned VRAM_BYTES = 2048
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [1:0]  req_size,
  input  logic [23:0] req_addr,
  input  logic [31:0] req_wdata,
  output logic        rd_valid,
  output logic [31:0] rd_data,
  output logic [3:0]  region_sel,
  output logic        unmapped_pulse,
  output logic        map_normal
);

  localparam int unsigned ROM_AW  = $clog2(ROM_BYTES);
  localparam int unsigned RAM_AW  = $clog2(RAM_BYTES);
  localparam int unsigned VID_AW  = $clog2(VRAM_BYTES);
  localparam int unsigned ROM_ROWS = ROM_BYTES / 4;
  localparam int unsigned RAM_ROWS = RAM_BYTES / 4;
  localparam int unsigned VID_ROWS = VRAM_BYTES / 4;
  localparam int unsigned ROM_RW  = ROM_AW - 2;
  localparam int unsigned RAM_RW  = RAM_AW - 2;
  localparam int unsigned VID_RW  = VID_AW - 2;

  logic [23:0] eff_addr;
  region_e     region;
  logic        is_ctrl;
  logic [2:0]  nb;

  assign nb = size_bytes(req_size);

  bdec_region_decode #(.RAM_BYTES(RAM_BYTES)) u_decode (
    .req_addr  (req_addr),
    .map_normal(map_normal),
    .eff_addr  (eff_addr),
    .region    (region),
    .is_ctrl   (is_ctrl)
  );

  logic wr_ram, wr_vid, ctrl_wr;
  assign wr_ram  = req_valid && req_write && (region == RG_RAM);
  assign wr_vid  = req_valid && req_write && (region == RG_VID);
  assign ctrl_wr = req_valid && req_write && is_ctrl;

  logic [3:0][ROM_RW-1:0] rom_row;
  logic [3:0]             rom_we;
  logic [3:0][7:0]        rom_wb;
  logic [3:0][RAM_RW-1:0] ram_row;
  logic [3:0]             ram_we;
  logic [3:0][7:0]        ram_wb;
  logic [3:0][VID_RW-1:0] vid_row;
  logic [3:0]             vid_we;
  logic [3:0][7:0]        vid_wb;

  bdec_lane_steer #(.MEM_BYTES(ROM_BYTES)) u_steer_rom (
    .base(eff_addr[ROM_AW-1:0]), .nbytes(nb), .wr(1'b0), .wdata(req_wdata),
    .row(rom_row), .we(rom_we), .wbyte(rom_wb)
  );
  bdec_lane_steer #(.MEM_BYTES(RAM_BYTES)) u_steer_ram (
    .base(eff_addr[RAM_AW-1:0]), .nbytes(nb), .wr(wr_ram), .wdata(req_wdata),
    .row(ram_row), .we(ram_we), .wbyte(ram_wb)
  );
  bdec_lane_steer #(.MEM_BYTES(VRAM_BYTES)) u_steer_vid (
    .base(eff_addr[VID_AW-1:0]), .nbytes(nb), .wr(wr_vid), .wdata(req_wdata),
    .row(vid_row), .we(vid_we), .wbyte(vid_wb)
  );

  logic [3:0][7:0] rom_rd, ram_rd, vid_rd;

  for (genvar L = 0; L < 4; L++) begin : g_bank
    bdec_rom_lane #(.ROWS(ROM_ROWS), .LANE(L)) u_rom (
      .clk(clk), .row(rom_row[L]), .rdata(rom_rd[L])
    );
    bdec_ram_lane #(.ROWS(RAM_ROWS)) u_ram (
      .clk(clk), .we(ram_we[L]), .row(ram_row[L]), .wdata(ram_wb[L]), .rdata(ram_rd[L])
    );
    bdec_ram_lane #(.ROWS(VID_ROWS)) u_vid (
      .clk(clk), .we(vid_we[L]), .row(vid_row[L]), .wdata(vid_wb[L]), .rdata(vid_rd[L])
    );
  end

  region_e    region_q;
  logic [2:0] nb_q;
  logic [1:0] lo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      map_normal     <= 1'b0;
      rd_valid       <= 1'b0;
      region_sel     <= 4'b0000;
      unmapped_pulse <= 1'b0;
      region_q       <= RG_BOOT;
      nb_q           <= 3'd1;
      lo_q           <= 2'd0;
    end else begin
      if (ctrl_wr) begin
        map_normal <= (nb == 3'd1) ? req_wdata[7] : req_wdata[15];
      end
      rd_valid       <= req_valid && !req_write;
      region_sel     <= req_valid ? (4'b0001 << region) : 4'b0000;
      unmapped_pulse <= req_valid && (region == RG_REG) && !(req_write && is_ctrl);
      if (req_valid) begin
        region_q <= region;
        nb_q     <= nb;
        lo_q     <= eff_addr[1:0];
      end
    end
  end

  logic [3:0][7:0] lane_q;

  always_comb begin
    case (region_q)
      RG_BOOT: lane_q = rom_rd;
      RG_RAM:  lane_q = ram_rd;
      default: lane_q = vid_rd;
    endcase
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < 4; i++) begin
      if (i < int'(nb_q)) begin
        rd_data[8*(int'(nb_q)-1-i) +: 8] = lane_q[2'(int'(lo_q) + i)];
      end
    end
    if (region_q == RG_REG) rd_data = ones_of(nb_q);
  end

  assert_sel_onehot_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(region_sel));

  assert_read_latency_R11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> rd_valid);

  assert_no_write_valid_R11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write) |=> !rd_valid);

  assert_reset_overlay_R1: assert property (@(posedge clk)
    $past(rst) |-> !map_normal);

  assert_overlay_no_ram_R1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !map_normal) |=> !(region_sel[1] || region_sel[2]));

  assert_flag_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !ctrl_wr |=> $stable(map_normal));

  assert_pulse_region_R10: assert property (@(posedge clk) disable iff (rst)
    unmapped_pulse |-> region_sel[3]);

  assert_boot_no_write_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && region == RG_BOOT) |-> !(ram_we != 4'b0 || vid_we != 4'b0));

endmodule

// File: tb/tb_boot_overlay_bus_decoder.sv
module tb_boot_overlay_bus_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 20000;

  typedef struct packed {
    logic        wr;
    logic [1:0]  sz;
    logic [23:0] addr;
    logic [31:0] data;
    logic [3:0]  sel;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'd2, 24'h000100, 32'h11223344, 4'b0010},
    '{1'b0, 2'd2, 24'h000100, 32'h11223344, 4'b0010},
    '{1'b0, 2'd0, 24'h000101, 32'h00000022, 4'b0010},
    '{1'b0, 2'd1, 24'h000102, 32'h00003344, 4'b0010},
    '{1'b1, 2'd0, 24'h000102, 32'h000000AB, 4'b0010},
    '{1'b0, 2'd2, 24'h000100, 32'h1122AB44, 4'b0010},
    '{1'b1, 2'd2, 24'h000202, 32'hCAFEF00D, 4'b0010},
    '{1'b0, 2'd1, 24'h000204, 32'h0000F00D, 4'b0010},
    '{1'b0, 2'd2, 24'h000202, 32'hCAFEF00D, 4'b0010},
    '{1'b1, 2'd1, 24'h420010, 32'h0000BEEF, 4'b0100},
    '{1'b0, 2'd1, 24'h427810, 32'h0000BEEF, 4'b0100},
    '{1'b0, 2'd0, 24'h420011, 32'h000000EF, 4'b0100},
    '{1'b0, 2'd2, 24'h800000, 32'hC3C2C1C0, 4'b0001},
    '{1'b0, 2'd0, 24'hBFFC05, 32'h000000C6, 4'b0001},
    '{1'b0, 2'd1, 24'h800102, 32'h0000C0C1, 4'b0001},
    '{1'b1, 2'd2, 24'h800100, 32'h00000000, 4'b0001},
    '{1'b0, 2'd1, 24'h800102, 32'h0000C0C1, 4'b0001},
    '{1'b0, 2'd0, 24'h600000, 32'h000000FF, 4'b1000},
    '{1'b0, 2'd1, 24'h600002, 32'h0000FFFF, 4'b1000},
    '{1'b0, 2'd2, 24'hE43004, 32'hFFFFFFFF, 4'b1000},
    '{1'b0, 2'd1, 24'hE43000, 32'h0000FFFF, 4'b1000}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [23:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic [3:0]  region_sel;
  logic        unmapped_pulse;
  logic        map_normal;

  int checks = 0;
  int errors = 0;

  boot_overlay_bus_decoder dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .region_sel(region_sel),
    .unmapped_pulse(unmapped_pulse), .map_normal(map_normal)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] img(input int k);
    logic [31:0] kk;
    kk = 32'(k);
    return kk[7:0] ^ kk[15:8] ^ 8'hC3;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [1:0] sz,
                        input logic [23:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_size  = sz;
    req_addr  = a;
    req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    req_write = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=done", WATCHDOG);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 map_normal after reset", {31'b0, map_normal}, 32'd0);
    check("R11 rd_valid after reset", {31'b0, rd_valid}, 32'd0);
    check("R9 region_sel after reset", {28'b0, region_sel}, 32'd0);

    // R1 overlay: address zero reads the boot image
    access(1'b0, 2'd2, 24'h000000, 32'h0);
    check("R1 overlay read at zero", rd_data, {img(0), img(1), img(2), img(3)});
    check("R9 overlay region boot", {28'b0, region_sel}, 32'h1);
    check("R11 rd_valid on read", {31'b0, rd_valid}, 32'd1);

    // R7 control register, size-dependent data bit
    access(1'b1, 2'd1, 24'hE43000, 32'h00008000);
    check("R7 word write bit15 set", {31'b0, map_normal}, 32'd1);
    check("R10 no pulse on ctrl write", {31'b0, unmapped_pulse}, 32'd0);
    check("R11 no rd_valid on write", {31'b0, rd_valid}, 32'd0);
    access(1'b1, 2'd0, 24'hE43000, 32'h0000007F);
    check("R7 byte write bit7 clear", {31'b0, map_normal}, 32'd0);
    access(1'b1, 2'd0, 24'hE43000, 32'h00000080);
    check("R7 byte write bit7 set", {31'b0, map_normal}, 32'd1);
    access(1'b1, 2'd1, 24'hE43000, 32'h00000080);
    check("R7 word write ignores bit7", {31'b0, map_normal}, 32'd0);
    access(1'b1, 2'd2, 24'hE43000, 32'h00008000);
    check("R7 long write bit15 set", {31'b0, map_normal}, 32'd1);

    // R10 other register address
    access(1'b1, 2'd1, 24'hE43002, 32'h00000000);
    check("R10 other reg leaves flag", {31'b0, map_normal}, 32'd1);
    check("R10 pulse on other reg", {31'b0, unmapped_pulse}, 32'd1);
    @(negedge clk);
    check("R10 pulse lasts one cycle", {31'b0, unmapped_pulse}, 32'd0);

    // vector table (normal map): R2 R3 R4 R5 R6 R8 R9 R12
    for (int n = 0; n < NV; n++) begin
      access(VEC[n].wr, VEC[n].sz, VEC[n].addr, VEC[n].data);
      check($sformatf("R9 table %0d region", n), {28'b0, region_sel}, {28'b0, VEC[n].sel});
      check($sformatf("R10 table %0d pulse", n), {31'b0, unmapped_pulse},
            {31'b0, VEC[n].sel == 4'b1000});
      if (!VEC[n].wr) begin
        check($sformatf("R5 table %0d rd_data", n), rd_data, VEC[n].data);
        check($sformatf("R11 table %0d rd_valid", n), {31'b0, rd_valid}, 32'd1);
      end
    end

    // R6 / R1: overlay write to a low address goes to the image, RAM kept
    access(1'b1, 2'd0, 24'h000010, 32'h00000011);
    access(1'b1, 2'd1, 24'hE43000, 32'h00000000);
    check("R7 overlay restored", {31'b0, map_normal}, 32'd0);
    access(1'b1, 2'd0, 24'h000010, 32'h00000099);
    check("R6 overlay write hits boot region", {28'b0, region_sel}, 32'h1);
    access(1'b0, 2'd0, 24'h000010, 32'h0);
    check("R1 overlay byte read", rd_data, {24'b0, img(16'h10)});
    access(1'b1, 2'd1, 24'hE43000, 32'h00008000);
    access(1'b0, 2'd0, 24'h000010, 32'h0);
    check("R3 RAM kept after overlay write", rd_data, 32'h00000011);
    check("R9 low address is RAM", {28'b0, region_sel}, 32'h2);

    // R1 reset restores overlay mapping
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset clears flag", {31'b0, map_normal}, 32'd0);
    access(1'b0, 2'd2, 24'h000100, 32'h0);
    check("R1 reset maps image at zero", rd_data,
          {img(16'h100), img(16'h101), img(16'h102), img(16'h103)});

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule